// File: doc/BRIEF.md
# Connection Memory Parity Scanner with First-Error Trap

This block keeps a word-wide connection memory under constant watch. A scan pointer visits one entry on each clock-enable pulse and wraps from the top entry back to zero. Every word is read together with a check bit that was stored when the word was written. When a word and its check bit do not give even parity, the block raises a sticky error flag and records the failing entry index in a trap register.

Only the first failing index after a clear is recorded. Later mismatches leave the trap untouched until software clears the flag. A mode pin sets how software clears the flag. In one mode, reading the trap register clears it. In the other mode, any write to the trap register clears it, whatever the data. The flag is also driven out as a level for an interrupt collector. A test input lets one write store an inverted check bit, so that faults can be planted on purpose.

Top module: `cs_parity_scan_trap`

## Requirements
- R1: After reset the error flag is 0 and the trap register reads 0.
- R2: The scan pointer starts at entry 0, moves by one entry on each cycle with `scan_tick` high, holds while it is low, and wraps from entry DEPTH-1 to entry 0, so every entry including the first and the last is examined.
- R3: A write stores a check bit that makes data plus check bit even parity; `mem_wr_bad` inverts it. Words written with a correct check bit never raise the flag.
- R4: A parity mismatch found by the scan sets `err_flag` and stores the entry index in trap register bits [ADDR_W-1:0]; bit 15 and all other bits above the index read 0.
- R5: While the flag is set, further mismatches do not change the trapped index.
- R6: `err_flag` is a level that stays high across any number of scans until a clear.
- R7: With `clr_mode` = 0 (clear-on-read), a `reg_rd` pulse clears the flag and a `reg_wr` pulse has no effect.
- R8: With `clr_mode` = 1 (clear-on-write), a `reg_wr` pulse clears the flag whatever `reg_wdata` holds, and a `reg_rd` pulse has no effect.
- R9: A clear and a newly detected mismatch in the same cycle leave the flag clear; that entry is trapped the next time the scan reaches it.
- R10: A clear does not change the trap register; it keeps the old index until a new mismatch is trapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | Clock enable: examine one entry and advance the pointer |
| clr_mode | input | 1 | 0 = clear on read, 1 = clear on write |
| mem_wr_en | input | 1 | Write one connection memory entry |
| mem_wr_addr | input | ADDR_W | Entry index to write |
| mem_wr_data | input | DATA_W | Word to write |
| mem_wr_bad | input | 1 | Store the inverted check bit for this write |
| reg_rd | input | 1 | Software read strobe for the trap register |
| reg_wr | input | 1 | Software write strobe for the trap register |
| reg_wdata | input | 16 | Write data (ignored apart from the strobe) |
| reg_rdata | output | 16 | Trap register contents |
| err_flag | output | 1 | Sticky parity error level |

## Verification
A scan pointer that skips or stalls shows up as a planted fault that is never trapped within one full sweep. The bench plants faults at both ends of the memory to catch this. A trap that overwrites its index, or a clear that does not work, shows in `reg_rdata` or `err_flag` at the next sample after the strobe or the sweep. A wrong priority between clear and capture shows one cycle after a detection that was timed to land on the same edge as a clear.

// File: rtl/cs_scan_pkg.sv
package cs_scan_pkg;

    localparam int REG_W = 16;

    typedef enum logic {
        CLR_ON_READ  = 1'b0,
        CLR_ON_WRITE = 1'b1
    } clr_mode_e;

    // returns 1 when the vector holds an odd number of ones
    function automatic logic odd_ones(input logic [63:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/cs_parity_ram.sv
module cs_parity_ram
    import cs_scan_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bad,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_chk
);

    typedef struct packed {
        logic              chk;
        logic [DATA_W-1:0] data;
    } cell_t;

    cell_t mem [DEPTH];
    cell_t rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr].data <= wr_data;
            mem[wr_addr].chk  <= odd_ones(64'(wr_data)) ^ wr_bad;
        end
        if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

    assign rd_data = rd_q.data;
    assign rd_chk  = rd_q.chk;

endmodule

// File: rtl/cs_scan_ctr.sv
module cs_scan_ctr #(
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (tick) begin
            addr <= (addr == LAST) ? '0 : addr + 1'b1;
        end
    end

    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (tick && addr == LAST) |=> (addr == '0));
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(addr));
    a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
        addr <= LAST);

endmodule

// File: rtl/cs_err_trap.sv
module cs_err_trap
    import cs_scan_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_valid,
    input  logic              chk_fail,
    input  logic [ADDR_W-1:0] chk_addr,
    input  clr_mode_e         mode,
    input  logic              reg_rd,
    input  logic              reg_wr,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              flag
);

    logic              clr;
    logic              hit;
    logic [ADDR_W-1:0] trap_q;

    initial begin
        assert (ADDR_W <= REG_W - 1) else $error("index wider than trap field");
    end

    always_comb begin
        unique case (mode)
            CLR_ON_READ:  clr = reg_rd;
            CLR_ON_WRITE: clr = reg_wr;
            default:      clr = 1'b0;
        endcase
    end

    assign hit = chk_valid && chk_fail;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag   <= 1'b0;
            trap_q <= '0;
        end else if (clr) begin
            flag <= 1'b0;
        end else if (hit && !flag) begin
            flag   <= 1'b1;
            trap_q <= chk_addr;
        end
    end

    assign reg_rdata = {1'b0, (REG_W-1)'(trap_q)};

    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        (hit && !flag && !clr) |=> (flag && reg_rdata == (REG_W)'($past(chk_addr))));
    a_r5_first_only: assert property (@(posedge clk) disable iff (rst)
        flag |=> $stable(reg_rdata));
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag);
    a_r10_clear_keeps_index: assert property (@(posedge clk) disable iff (rst)
        clr |=> $stable(reg_rdata));
    a_r4_top_bit_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[REG_W-1] == 1'b0);

endmodule

// File: rtl/cs_parity_scan_trap.sv
module cs_parity_scan_trap
    import cs_scan_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_tick,
    input  logic              clr_mode,
    input  logic              mem_wr_en,
    input  logic [ADDR_W-1:0] mem_wr_addr,
    input  logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_bad,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              err_flag
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } probe_t;

    logic [ADDR_W-1:0] scan_addr;
    logic [DATA_W-1:0] rd_data;
    logic              rd_chk;
    logic              mismatch;
    probe_t            probe_q;
    logic              unused_wdata;

    // write data carries no meaning; only the strobe matters
    assign unused_wdata = ^reg_wdata;

    cs_scan_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .tick (scan_tick),
        .addr (scan_addr)
    );

    cs_parity_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
        .clk     (clk),
        .wr_en   (mem_wr_en),
        .wr_addr (mem_wr_addr),
        .wr_data (mem_wr_data),
        .wr_bad  (mem_wr_bad),
        .rd_en   (scan_tick),
        .rd_addr (scan_addr),
        .rd_data (rd_data),
        .rd_chk  (rd_chk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            probe_q <= '0;
        end else begin
            probe_q.valid <= scan_tick;
            probe_q.addr  <= scan_addr;
        end
    end

    assign mismatch = odd_ones(64'({rd_chk, rd_data}));

    cs_err_trap #(.ADDR_W(ADDR_W)) u_trap (
        .clk       (clk),
        .rst       (rst),
        .chk_valid (probe_q.valid),
        .chk_fail  (mismatch),
        .chk_addr  (probe_q.addr),
        .mode      (clr_mode_e'(clr_mode)),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_rdata (reg_rdata),
        .flag      (err_flag)
    );

    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (!clr_mode && reg_rd) |=> !err_flag);
    a_r8_write_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_mode && reg_wr) |=> !err_flag);
    a_r2_probe_follows_tick: assert property (@(posedge clk) disable iff (rst)
        scan_tick |=> (probe_q.valid && probe_q.addr == $past(scan_addr)));

endmodule

// File: tb/test_cs_parity_scan_trap.sv
module test_cs_parity_scan_trap;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 256;
    localparam int DATA_W = 8;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int SWEEP  = DEPTH + 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              scan_tick = 1'b0;
    logic              clr_mode = 1'b0;
    logic              mem_wr_en = 1'b0;
    logic [ADDR_W-1:0] mem_wr_addr = '0;
    logic [DATA_W-1:0] mem_wr_data = '0;
    logic              mem_wr_bad = 1'b0;
    logic              reg_rd = 1'b0;
    logic              reg_wr = 1'b0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic              err_flag;

    int checks = 0;
    int fails  = 0;
    int ticks  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_parity_scan_trap #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_cs_parity_scan_trap (
        .clk, .rst, .scan_tick, .clr_mode, .mem_wr_en, .mem_wr_addr,
        .mem_wr_data, .mem_wr_bad, .reg_rd, .reg_wr, .reg_wdata,
        .reg_rdata, .err_flag
    );

    function automatic logic [15:0] exp_reg(input int idx);
        return {1'b0, 15'(idx)};
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_word(input int idx, input logic [DATA_W-1:0] d, input logic bad);
        mem_wr_en = 1'b1; mem_wr_addr = ADDR_W'(idx); mem_wr_data = d; mem_wr_bad = bad;
        step();
        mem_wr_en = 1'b0; mem_wr_bad = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        scan_tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            step();
            ticks++;
        end
        scan_tick = 1'b0;
        step();
    endtask

    task automatic strobe(input bit rd, input bit wr, input logic [15:0] wd);
        reg_rd = rd; reg_wr = wr; reg_wdata = wd;
        step();
        reg_rd = 1'b0; reg_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int a, b, s;
        void'($urandom(32'd1234));
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: reset state
        check(16'(err_flag), 16'd0, "R1 flag");
        check(reg_rdata, 16'd0, "R1 trap");

        for (int i = 0; i < DEPTH; i++) write_word(i, DATA_W'($urandom), 1'b0);
        // R3: good words never flag
        run_ticks(2 * SWEEP);
        check(16'(err_flag), 16'd0, "R3 clean");

        // R2: last entry is reached
        write_word(DEPTH - 1, 8'hA5, 1'b1);
        run_ticks(SWEEP);
        check(16'(err_flag), 16'd1, "R2 last flag");
        check(reg_rdata, exp_reg(DEPTH - 1), "R2 last idx");
        write_word(DEPTH - 1, 8'hA5, 1'b0);
        clr_mode = 1'b0;
        strobe(1'b1, 1'b0, 16'h0);
        check(16'(err_flag), 16'd0, "R7 read clears");
        // R10: index kept after clear
        check(reg_rdata, exp_reg(DEPTH - 1), "R10 kept");

        // R2: entry zero after wrap
        write_word(0, 8'h00, 1'b1);
        run_ticks(SWEEP);
        check(reg_rdata, exp_reg(0), "R2 zero idx");
        check(16'(err_flag), 16'd1, "R4 flag");
        write_word(0, 8'h00, 1'b0);
        // R7: write ignored in clear-on-read mode
        strobe(1'b0, 1'b1, 16'hFFFF);
        check(16'(err_flag), 16'd1, "R7 write ignored");
        strobe(1'b1, 1'b0, 16'h0);

        // random rounds: R4, R5, R6, R8
        for (int r = 0; r < 12; r++) begin
            a = int'($urandom_range(DEPTH - 1));
            b = (a + 1 + int'($urandom_range(DEPTH - 2))) % DEPTH;
            write_word(a, DATA_W'($urandom), 1'b1);
            run_ticks(SWEEP);
            check(reg_rdata, exp_reg(a), "R4 idx");
            write_word(b, DATA_W'($urandom), 1'b1);
            run_ticks(SWEEP + int'($urandom_range(40)));
            check(reg_rdata, exp_reg(a), "R5 first only");
            check(16'(err_flag), 16'd1, "R6 sticky");
            write_word(a, DATA_W'($urandom), 1'b0);
            write_word(b, DATA_W'($urandom), 1'b0);
            clr_mode = 1'b1;
            strobe(1'b1, 1'b0, 16'h0);
            check(16'(err_flag), 16'd1, "R8 read ignored");
            strobe(1'b0, 1'b1, 16'($urandom));
            check(16'(err_flag), 16'd0, "R8 write clears");
            check(reg_rdata, exp_reg(a), "R10 kept");
            clr_mode = 1'b0;
        end

        // R9: detection lands on the clear edge
        s = ticks % DEPTH;
        write_word(s, 8'h3C, 1'b1);
        scan_tick = 1'b1;
        step();
        ticks++;
        scan_tick = 1'b0;
        reg_rd = 1'b1;
        step();
        reg_rd = 1'b0;
        check(16'(err_flag), 16'd0, "R9 clear wins");
        step();
        check(16'(err_flag), 16'd0, "R9 still clear");
        run_ticks(SWEEP);
        check(16'(err_flag), 16'd1, "R9 retrapped");
        check(reg_rdata, exp_reg(s), "R9 idx");
        check(16'(reg_rdata[15]), 16'd0, "R4 bit15");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule